// File: doc/BRIEF.md
# Iterative Logarithmic 4x4 Multiplier

This block multiplies two unsigned 4-bit operands exactly, without a partial-product array. It uses a chain of logarithmic approximation stages. Each stage locates the most significant set bit of both of its operands. From those two positions it forms an approximate product using only shifts, a decoded power of two and two additions. It then strips the top set bit from each operand and passes the two residuals to the next stage.

The error of one stage equals the product of the two residuals, and each stage removes one set bit from each operand. With as many stages as the operand is wide, the residuals are exhausted. The sum of the stage outputs is therefore the exact product.

The sum is captured in an output register when the input valid is high. The registered result appears with its valid flag on the following cycle. When the input valid is low, the register keeps its value. The block is meant as the leaf multiplier of a larger recursive multiplier, for example inside a pixel-filter datapath.

Top module: `mitchell_iter_mul4`

## Requirements
- R1: One cycle after a clock edge where `in_valid` is high, `product` equals the exact unsigned product `opa*opb` for every one of the 256 operand pairs.
- R2: `out_valid` is high in exactly the cycle after a clock edge where `in_valid` was high, and low after an edge where `in_valid` was low.
- R3: After an edge where `in_valid` is low, `product` keeps its previous value, whatever the operands are.
- R4: If either operand is zero, the registered product is zero. A zero operand stops every stage from contributing.
- R5: While `rst_n` is low, `product` reads 0 and `out_valid` reads 0.
- R6: If both operands are powers of two (2^i and 2^j), the result is 2^(i+j). This is the decoded power-of-two term of the first stage alone, because both residuals are then zero.
- R7: Operands with every bit set (15 x 15) give 225. All four stages contribute, and the 8-bit sum does not overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid and are captured at this edge |
| opa | input | 4 | First unsigned operand |
| opb | input | 4 | Second unsigned operand |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 8 | Registered exact product |

## Verification
The assertions assume that the operands are stable and known at every clock edge where `in_valid` is high. The reference they use for the product is the operand values sampled at that edge. The bench drives inputs only on falling edges, so the operands are always settled before a rising edge. During idle cycles it also changes the operands with `in_valid` low. This keeps the assumption honest while still exercising the hold behaviour.

// File: rtl/mitchell_iter_mul4.sv
module mitchell_iter_mul4 #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;
  localparam int KW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  function automatic logic [KW-1:0] lead_one(input logic [WIDTH-1:0] v);
    logic [KW-1:0] pos;
    pos = '0;
    for (int i = 0; i < WIDTH; i++)
      if (v[i]) pos = KW'(i);
    return pos;
  endfunction

  logic [WIDTH-1:0] res_a [STAGES+1];
  logic [WIDTH-1:0] res_b [STAGES+1];
  logic [PW-1:0]    acc   [STAGES+1];

  assign res_a[0] = opa;
  assign res_b[0] = opb;
  assign acc[0]   = '0;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [KW-1:0]    k1, k2;
    logic [KW:0]      ksum;
    logic             zero;
    logic [WIDTH-1:0] top_a, top_b, rem_a, rem_b;
    logic [PW-1:0]    pow, sh_a, sh_b, term;

    assign k1    = lead_one(res_a[g]);
    assign k2    = lead_one(res_b[g]);
    assign zero  = ~|res_a[g] | ~|res_b[g];
    assign top_a = WIDTH'(1) << k1;
    assign top_b = WIDTH'(1) << k2;
    assign rem_a = res_a[g] ^ top_a;
    assign rem_b = res_b[g] ^ top_b;
    assign ksum  = {1'b0, k1} + {1'b0, k2};
    assign pow   = PW'(1) << ksum;
    assign sh_a  = PW'(rem_a) << k2;
    assign sh_b  = PW'(rem_b) << k1;
    assign term  = zero ? '0 : pow + sh_a + sh_b;

    assign res_a[g+1] = zero ? '0 : rem_a;
    assign res_b[g+1] = zero ? '0 : rem_b;
    assign acc[g+1]   = acc[g] + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= acc[STAGES];
    end
  end
endmodule

// File: rtl/mitchell_iter_mul4_chk.sv
module mitchell_iter_mul4_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [WIDTH-1:0]   opa,
  input logic [WIDTH-1:0]   opb,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  assert_exact_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> product == (PW'($past(opa)) * PW'($past(opb))));

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));

  assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opa == '0 || opb == '0)) |=> product == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product <= PW'(((1 << WIDTH) - 1) * ((1 << WIDTH) - 1)));
endmodule

bind mitchell_iter_mul4 mitchell_iter_mul4_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
  .out_valid(out_valid), .product(product)
);

// File: tb/mitchell_iter_mul4_bench.sv
module mitchell_iter_mul4_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] opa = '0, opb = '0;
  logic       out_valid;
  logic [7:0] product;
  int         n_vec = 0, n_bad = 0;
  logic [7:0] last = '0;

  always #2 clk = ~clk;

  mitchell_iter_mul4 u_mitchell_iter_mul4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
    .out_valid(out_valid), .product(product)
  );

  function automatic logic [7:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
    return 8'(a) * 8'(b);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input string req);
    opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    check(req, product, ref_mul(a, b));
    check("R2", {7'd0, out_valid}, 8'd1);
    last = ref_mul(a, b);
  endtask

  task automatic idle(input logic [3:0] a, input logic [3:0] b);
    opa = a; opb = b; in_valid = 1'b0;
    @(negedge clk);
    check("R3", product, last);
    check("R2", {7'd0, out_valid}, 8'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    @(negedge clk);
    check("R5", product, 8'd0);
    check("R5", {7'd0, out_valid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 exhaustive streaming sweep
    for (int p = 0; p < 256; p++) apply(4'(p >> 4), 4'(p), "R1");
    idle(4'd9, 4'd7);

    // R4 zero operands
    apply(4'd0, 4'd13, "R4");
    apply(4'd11, 4'd0, "R4");
    apply(4'd0, 4'd0, "R4");

    // R6 powers of two
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) apply(4'(1 << i), 4'(1 << j), "R6");

    // R7 all bits set
    apply(4'd15, 4'd15, "R7");
    idle(4'd1, 4'd1);
    idle(4'd15, 4'd3);

    // R1 random with idle gaps, R3 hold
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) == 0) idle(4'($urandom), 4'($urandom));
      else apply(4'($urandom), 4'($urandom), "R1");
    end

    // R5 reset clears
    rst_n = 1'b0;
    #1;
    check("R5", product, 8'd0);
    check("R5", {7'd0, out_valid}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule